// File: doc/BRIEF.md
# Local Bus Cycle Sequencer

This block steps a processor's local bus through its cycle phases: idle, address, data, wait, recovery and hold. The core hands it one request at a time, carrying a direction, a burst length and an atomic flag. The block then works the bus side through one input and three outputs:

- It watches a single active-low ready/recover input.
- It answers an external master's HOLD request with HOLDA.
- It drives an active-low LOCK line.
- It drives an output-enable for the shared address/data and control lines.

The ready/recover input has two meanings, depending on the phase:

- **In a data beat**, a low level completes the beat, and a high level inserts a wait state.
- **In recovery**, a high level ends recovery, and a low level stretches it by one more cycle.

An atomic request is a read half followed by a write half of the same length. LOCK stays active across both halves, so no external master can take the bus between the read and the write.

Top module: `bus_cycle_seq`

## Requirements
- R1: During and after a synchronous active-low reset, the outputs are as follows until the first request or hold: `bus_state` = IDLE, `hold_ack` = 0, `lock_n` = 1 and `bus_oe` = 1. The state codes are IDLE=0, ADDR=1, DATA=2, WAIT=3, RECOV=4, HOLD=5.
- R2: In IDLE with `req_valid` high and `hold_req` low, `req_accept` is high in that same cycle. The next cycle is ADDR, and the one after that is DATA.
- R3: In DATA or WAIT with `bus_rdy_n` high, the next cycle is WAIT. This repeats every clock until `bus_rdy_n` is sampled low.
- R4: `req_len` holds the beat count minus one. A request of N beats completes N data beats (each sampled with `bus_rdy_n` low), and only the last of them leads to RECOV. Earlier beats lead to DATA.
- R5: In RECOV, `bus_rdy_n` low keeps the block in RECOV. Sampling `bus_rdy_n` high completes recovery, and only after that can a new ADDR follow.
- R6: A hold is granted, moving to HOLD, only from IDLE or at the completion of recovery, and only when no lock is held. Hold takes priority over a pending request. In HOLD, `hold_ack` is 1 and `bus_oe` is 0; in every other state `hold_ack` is 0 and `bus_oe` is 1.
- R7: In HOLD with `hold_req` low, the next state is RECOV if `req_valid` is high, and IDLE otherwise.
- R8: In HOLD, `req_accept` stays 0 whatever `req_valid` does. The request stays pending and is accepted only after the bus has been reclaimed.
- R9: An atomic request (`req_atomic` = 1) runs a read half of N beats, then RECOV, then ADDR, then a write half of N beats. `bus_wr` is 0 in the read half and 1 in the write half, and `req_write` is ignored.
- R10: `lock_n` goes low in the first ADDR cycle of an atomic request. It stays low through the final data beat of the write half and is high in the recovery that follows.
- R11: `hold_ack` is never 1 while `lock_n` is 0. A hold request that arrives between the two halves of an atomic request waits until the lock drops.
- R12: For a plain request, `bus_wr` equals the accepted `req_write` during its ADDR, DATA and WAIT cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Core request pending; held until accepted |
| req_write | input | 1 | 1 = write, 0 = read (plain requests) |
| req_atomic | input | 1 | Atomic read-then-write request |
| req_len | input | LEN_W | Beat count minus one |
| req_accept | output | 1 | Request taken this cycle |
| bus_rdy_n | input | 1 | Ready/recover, active low |
| hold_req | input | 1 | External master requests the bus |
| hold_ack | output | 1 | Bus handed to the external master |
| lock_n | output | 1 | Atomic sequence in progress, active low |
| bus_oe | output | 1 | Drive enable for address/data and control lines |
| bus_wr | output | 1 | Direction of the current cycle |
| bus_state | output | 3 | Current phase code (see R1) |

## Verification
A behavioural model in the bench is stepped alongside the design and compared every cycle. It runs under four stimulus mixes:

- **Ready always low, no hold.** This exposes the bare address–data–recovery rhythm and the burst beat count.
- **Ready mostly high.** This drives long wait chains and stretched recoveries, and separates the data meaning of the ready input from its recovery meaning.
- **Busy hold line with plain requests.** This tests the grant-only-at-boundary rule, hold priority, and the choice between recovery and idle on the way out of hold.
- **Mostly atomic requests under a busy hold line.** This shows whether lock timing and hold blocking between the two halves are right.

// File: rtl/bseq_pkg.sv
// Shared types for the local bus cycle sequencer.
// Assumes: the state codes below are visible at the top-level port bus_state.
package bseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_DATA  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_RECOV = 3'd4,
        ST_HOLD  = 3'd5
    } bseq_state_e;
endpackage

// File: rtl/bseq_beat_cnt.sv
// Beat counter: it counts the data beats left in the current burst half.
// Assumes: load and reload never coincide with beat_done.
module bseq_beat_cnt #(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             reload,
    input  logic [LEN_W-1:0] len_in,
    input  logic             beat_done,
    output logic             last
);
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] len_keep;

    // Keep the request length so an atomic write half can replay it.
    always_ff @(posedge clk) begin
        if (!rst_n)    len_keep <= '0;
        else if (load) len_keep <= len_in;
    end

    // Count down the remaining beats of the active half.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= len_in;
        else if (reload)            cnt <= len_keep;
        else if (beat_done && !last) cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/bseq_lock_trk.sv
// Lock tracker: it holds the atomic lock, which half is active, and the direction.
// Assumes: final_done pulses once, when the last beat of a half completes.
module bseq_lock_trk (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic req_atomic,
    input  logic req_write,
    input  logic final_done,
    output logic locked,
    output logic wr_half,
    output logic dir_wr
);
    logic plain_wr;

    // Update the lock and half flags at acceptance and at each half's final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked  <= 1'b0;
            wr_half <= 1'b0;
        end else if (accept) begin
            locked  <= req_atomic;
            wr_half <= 1'b0;
        end else if (final_done && locked) begin
            if (!wr_half) begin
                wr_half <= 1'b1;
            end else begin
                locked  <= 1'b0;
                wr_half <= 1'b0;
            end
        end
    end

    // Latch the direction of a plain request; atomic requests start as a read.
    always_ff @(posedge clk) begin
        if (!rst_n)      plain_wr <= 1'b0;
        else if (accept) plain_wr <= req_write & ~req_atomic;
    end

    assign dir_wr = plain_wr | wr_half;
endmodule

// File: rtl/bseq_hold_gate.sv
// Hold gate: it decides whether the bus may be handed off this cycle.
// Assumes: at_boundary is true only in idle or on the cycle that completes recovery.
module bseq_hold_gate (
    input  logic at_boundary,
    input  logic hold_req,
    input  logic locked,
    output logic grant
);
    // Grant only at a cycle boundary and never while an atomic lock is held.
    always_comb grant = at_boundary & hold_req & ~locked;
endmodule

// File: rtl/bus_cycle_seq.sv
// Local bus cycle sequencer: it steps idle/address/data/wait/recovery/hold phases,
// stretches data beats and recovery through one ready/recover input, hands the bus to
// an external master, and keeps that master out of atomic sequences.
// Assumes: the core holds req_valid and its fields steady until req_accept.
module bus_cycle_seq
    import bseq_pkg::*;
#(
    parameter  int MAX_BEATS = 8,
    localparam int LEN_W     = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_atomic,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_accept,
    input  logic             bus_rdy_n,
    input  logic             hold_req,
    output logic             hold_ack,
    output logic             lock_n,
    output logic             bus_oe,
    output logic             bus_wr,
    output logic [2:0]       bus_state
);
    bseq_state_e state, state_nx;
    logic in_beat, beat_done, recov_done, at_boundary;
    logic grant, last, locked, wr_half, reload;

    // Decode the cycle events that drive the sub-blocks.
    always_comb begin
        in_beat     = (state == ST_DATA) || (state == ST_WAIT);
        beat_done   = in_beat && !bus_rdy_n;
        recov_done  = (state == ST_RECOV) && bus_rdy_n;
        at_boundary = (state == ST_IDLE) || recov_done;
        reload      = recov_done && locked;
        req_accept  = req_valid && at_boundary && !grant && !locked;
    end

    bseq_hold_gate u_hold (
        .at_boundary (at_boundary),
        .hold_req    (hold_req),
        .locked      (locked),
        .grant       (grant)
    );

    bseq_beat_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (req_accept),
        .reload    (reload),
        .len_in    (req_len),
        .beat_done (beat_done),
        .last      (last)
    );

    bseq_lock_trk u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (req_accept),
        .req_atomic (req_atomic),
        .req_write  (req_write),
        .final_done (beat_done && last),
        .locked     (locked),
        .wr_half    (wr_half),
        .dir_wr     (bus_wr)
    );

    // Next-phase selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (grant)           state_nx = ST_HOLD;
                else if (req_accept) state_nx = ST_ADDR;
            end
            ST_ADDR: state_nx = ST_DATA;
            ST_DATA, ST_WAIT: begin
                if (bus_rdy_n) state_nx = ST_WAIT;
                else if (last) state_nx = ST_RECOV;
                else           state_nx = ST_DATA;
            end
            ST_RECOV: begin
                if (!bus_rdy_n)                  state_nx = ST_RECOV;
                else if (grant)                  state_nx = ST_HOLD;
                else if (reload || req_accept)   state_nx = ST_ADDR;
                else                             state_nx = ST_IDLE;
            end
            ST_HOLD: begin
                if (!hold_req)       state_nx = req_valid ? ST_RECOV : ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Outputs decoded from the phase register and the lock flag.
    always_comb begin
        hold_ack  = (state == ST_HOLD);
        bus_oe    = (state != ST_HOLD);
        lock_n    = ~locked;
        bus_state = state;
    end

    // R11
    no_hold_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> lock_n);
    // R6
    hold_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> ($past(state) == ST_IDLE || $past(state) == ST_RECOV));
    // R10
    lock_starts_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> (state == ST_ADDR));
    // R3
    wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_beat && bus_rdy_n) |=> (state == ST_WAIT));
    // R5
    recov_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOV && !bus_rdy_n) |=> (state == ST_RECOV));
    // R8
    hold_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> !req_accept);
endmodule

// File: tb/bus_cycle_seq_tb.sv
// Bench: a behavioural reference model is stepped every clock and compared with the design.
module bus_cycle_seq_tb;
    localparam int MAXB = 8;
    localparam int LW   = $clog2(MAXB);
    localparam int S_IDLE = 0, S_ADDR = 1, S_DATA = 2, S_WAIT = 3, S_RECOV = 4, S_HOLD = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_atomic = 1'b0;
    logic [LW-1:0] req_len = '0;
    logic bus_rdy_n = 1'b0, hold_req = 1'b0;
    logic req_accept, hold_ack, lock_n, bus_oe, bus_wr;
    logic [2:0] bus_state;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model state
    int m_st = S_IDLE, m_left = 0, m_len = 0;
    bit m_wr = 0, m_lock = 0, m_second = 0;

    always #2 clk = ~clk;

    bus_cycle_seq #(.MAX_BEATS(MAXB)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_atomic(req_atomic), .req_len(req_len), .req_accept(req_accept),
        .bus_rdy_n(bus_rdy_n), .hold_req(hold_req), .hold_ack(hold_ack),
        .lock_n(lock_n), .bus_oe(bus_oe), .bus_wr(bus_wr), .bus_state(bus_state)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit exp_accept();
        if (m_st == S_IDLE) return req_valid && !hold_req;
        if (m_st == S_RECOV) return bus_rdy_n && !hold_req && !m_lock && req_valid;
        return 1'b0;
    endfunction

    task automatic compare_all();
        string st_tag;
        case (m_st)
            S_ADDR:  st_tag = "R2";
            S_DATA:  st_tag = "R4";
            S_WAIT:  st_tag = "R3";
            S_RECOV: st_tag = "R5";
            S_HOLD:  st_tag = "R6";
            default: st_tag = "R7";
        endcase
        chk(st_tag, "bus_state", int'(bus_state), m_st);
        chk(m_st == S_HOLD ? "R8" : "R2", "req_accept", int'(req_accept), int'(exp_accept()));
        chk(m_lock ? "R11" : "R6", "hold_ack", int'(hold_ack), int'(m_st == S_HOLD));
        chk("R6", "bus_oe", int'(bus_oe), int'(m_st != S_HOLD));
        chk("R10", "lock_n", int'(lock_n), int'(!m_lock));
        if (m_st == S_ADDR || m_st == S_DATA || m_st == S_WAIT)
            chk(m_lock ? "R9" : "R12", "bus_wr", int'(bus_wr), int'(m_wr || m_second));
    endtask

    task automatic take_req();
        m_len    = int'(req_len) + 1;
        m_left   = m_len;
        m_wr     = req_write && !req_atomic;
        m_lock   = req_atomic;
        m_second = 0;
    endtask

    task automatic model_step();
        case (m_st)
            S_IDLE: begin
                if (hold_req) m_st = S_HOLD;
                else if (req_valid) begin take_req(); m_st = S_ADDR; end
            end
            S_ADDR: m_st = S_DATA;
            S_DATA, S_WAIT: begin
                if (bus_rdy_n) m_st = S_WAIT;
                else begin
                    m_left--;
                    if (m_left == 0) begin
                        if (m_lock && !m_second) m_second = 1;
                        else begin m_lock = 0; m_second = 0; end
                        m_st = S_RECOV;
                    end else m_st = S_DATA;
                end
            end
            S_RECOV: begin
                if (bus_rdy_n) begin
                    if (hold_req && !m_lock) m_st = S_HOLD;
                    else if (m_lock) begin m_left = m_len; m_st = S_ADDR; end
                    else if (req_valid) begin take_req(); m_st = S_ADDR; end
                    else m_st = S_IDLE;
                end
            end
            default: begin
                if (!hold_req) m_st = req_valid ? S_RECOV : S_IDLE;
            end
        endcase
    endtask

    // One phase of stimulus with the given percentages.
    task automatic run_phase(input int cycles, input int p_req, input int p_wait,
                             input int p_hold_flip, input int p_atomic);
        for (int c = 0; c < cycles; c++) begin
            bit acc;
            @(negedge clk);
            if (!req_valid && ($urandom % 100) < p_req) begin
                req_valid  = 1'b1;
                req_write  = $urandom % 2;
                req_atomic = ($urandom % 100) < p_atomic;
                req_len    = LW'($urandom % MAXB);
            end
            bus_rdy_n = ($urandom % 100) < p_wait;
            if (($urandom % 100) < p_hold_flip) hold_req = ~hold_req;
            #1;
            compare_all();
            acc = exp_accept();
            @(posedge clk);
            model_step();
            #0;
            if (acc) req_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "bus_state", int'(bus_state), S_IDLE);
        chk("R1", "hold_ack", int'(hold_ack), 0);
        chk("R1", "lock_n", int'(lock_n), 1);
        chk("R1", "bus_oe", int'(bus_oe), 1);
        @(posedge clk);
        model_step();
        run_phase(3000, 60, 0, 0, 0);
        run_phase(3000, 60, 70, 0, 20);
        run_phase(3000, 50, 30, 15, 0);
        run_phase(4000, 70, 30, 20, 70);
        // drop hold and let the bus settle, still compared
        hold_req = 1'b0;
        run_phase(200, 0, 0, 0, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule